// File: doc/BRIEF.md
# DMA Channel Transfer Counter Engine

This block is the address and count core of a four-channel, byte-wide direct memory access controller. A register front end, which is not part of this block, loads each channel with a starting address, a transfer length, a page number and a mode. Devices then raise a per-channel request line. The engine picks one requesting channel and acknowledges it. For every byte it moves, it presents a 20-bit physical address and a direction strobe. It then steps the channel's address and count by one.

The length is loaded as "bytes minus one". The last byte of a transfer is flagged by a one-cycle terminal-count pulse. After that byte the count has wrapped to all ones. The address steps only inside its 16-bit field and never carries into the page, so one programmed transfer stays inside one 64 KB page. A per-channel mask pauses a channel without losing its position. A channel in auto-initialize mode reloads its starting values at terminal count. Otherwise the channel masks itself and stays stopped.

Top module: `dma_xfer_engine`

## Requirements
- R1: A channel loaded with count N moves exactly N+1 bytes before terminal count: N=0 moves one byte and N=FFFFh moves 65,536 bytes.
- R2: The 16-bit current address wraps (FFFFh to 0000h going up) without changing the page of that channel.
- R3: During a transfer, physAddr carries the channel's page in bits 19:16 and its current address, before stepping, in bits 15:0.
- R4: While a channel's mask bit is set it receives no acknowledge. Clearing the mask resumes from the current address and count, with no reload.
- R5: The transfer type code sets the strobes: 01 (write, device to memory) raises memWrite, 10 (read, memory to device) raises memRead, and 00 (verify) raises neither while still producing addresses and acknowledges.
- R6: With auto-initialize set, the byte at terminal count reloads the current address and count from the loaded base values, and the channel stays unmasked.
- R7: After each byte the address steps +1 when the decrement flag is 0 and -1 when it is 1.
- R8: tcPulse for a channel is high for exactly the one transfer cycle in which that channel's count steps from 0000h to FFFFh (or reloads), and at no other time.
- R9: Service mode code 01 (single) moves one byte per grant, so acknowledges are never back to back. Code 10 (block) moves every byte on consecutive cycles after one request, up to terminal count. Code 00 (demand) keeps moving bytes on consecutive cycles while the request stays high.
- R10: At most one acknowledge is high at a time. When several unmasked channels request, the lowest-numbered one is granted.
- R11: Without auto-initialize, terminal count sets the channel's own mask bit, and its current count then reads FFFFh.
- R12: After reset every channel is masked, no acknowledge or strobe is active, and current counts read 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load base and current values and the mode into channel cfgCh |
| cfgCh | input | 2 | Channel selected for loading |
| cfgBaseAddr | input | ADDR_W | Starting address |
| cfgBaseCount | input | ADDR_W | Length minus one |
| cfgPage | input | PAGE_W | Page number |
| cfgXferType | input | 2 | 00 verify, 01 write, 10 read |
| cfgAutoInit | input | 1 | Reload at terminal count |
| cfgAddrDown | input | 1 | 1 = decrement address |
| cfgSvcMode | input | 2 | 00 demand, 01 single, 10 block, 11 handled as single |
| maskWe | input | 1 | Write one mask bit |
| maskCh | input | 2 | Channel whose mask bit is written |
| maskVal | input | 1 | New mask value |
| dreq | input | 4 | Device request, one per channel |
| dack | output | 4 | Device acknowledge, one-hot during a transfer |
| tcPulse | output | 4 | Terminal-count pulse per channel |
| physAddr | output | PAGE_W+ADDR_W | Physical address of the current byte |
| memWrite | output | 1 | Device-to-memory byte |
| memRead | output | 1 | Memory-to-device byte |
| rdCh | input | 2 | Channel selected for readback |
| rdAddr | output | ADDR_W | Current address of rdCh |
| rdCount | output | ADDR_W | Current count of rdCh |
| maskOut | output | 4 | Mask bits of all channels |

## Verification
The assertions assume that the register front end never loads a channel in the same cycle that the channel is being serviced. The step and reload properties also exclude cycles in which a load or a mask write hits the channel being checked. The bench keeps to this by loading and masking a channel only while it has no request pending, except in the deliberate pause test, where it writes the mask of the active channel and never loads it. Request lines change only on falling edges, so the demand-mode transfer count is fixed by how many cycles the request is held.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    XFER_VERIFY = 2'b00,
    XFER_WRITE  = 2'b01,
    XFER_READ   = 2'b10,
    XFER_RSVD   = 2'b11
  } xferType_e;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'b00,
    SVC_SINGLE  = 2'b01,
    SVC_BLOCK   = 2'b10,
    SVC_CASCADE = 2'b11
  } svcMode_e;

  typedef struct packed {
    xferType_e xferType;
    logic      autoInit;
    logic      addrDown;
    svcMode_e  svcMode;
  } chanMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic            fire;  // move one byte on channel ch this cycle
    logic [CH_W-1:0] ch;    // channel owning the engine
  } xferStrobe_t;
endpackage

// File: rtl/dma_eng_datapath.sv
module dma_eng_datapath
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xferStrobe_t              strobe,
  input  logic                     cfgLoad,
  input  logic [CH_W-1:0]          cfgCh,
  input  logic [ADDR_W-1:0]        cfgBaseAddr,
  input  logic [ADDR_W-1:0]        cfgBaseCount,
  input  logic [PAGE_W-1:0]        cfgPage,
  input  chanMode_t                cfgMode,
  input  logic                     maskWe,
  input  logic [CH_W-1:0]          maskCh,
  input  logic                     maskVal,
  input  logic [CH_W-1:0]          rdCh,
  output logic [NUM_CH-1:0]        maskVec,
  output xferType_e                selType,
  output svcMode_e                 selSvc,
  output logic                     selTc,
  output logic [PAGE_W+ADDR_W-1:0] selPhys,
  output logic [ADDR_W-1:0]        rdAddr,
  output logic [ADDR_W-1:0]        rdCount
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] baseAddr [NUM_CH];
  logic [ADDR_W-1:0] baseCnt  [NUM_CH];
  logic [ADDR_W-1:0] curAddr  [NUM_CH];
  logic [ADDR_W-1:0] curCnt   [NUM_CH];
  logic [PAGE_W-1:0] pageReg  [NUM_CH];
  chanMode_t         modeReg  [NUM_CH];
  logic [NUM_CH-1:0] maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '1;
      for (int c = 0; c < NUM_CH; c++) begin
        baseAddr[c] <= '0;
        baseCnt[c]  <= '0;
        curAddr[c]  <= '0;
        curCnt[c]   <= '0;
        pageReg[c]  <= '0;
        modeReg[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfgLoad && cfgCh == CH_W'(c)) begin
          baseAddr[c] <= cfgBaseAddr;
          baseCnt[c]  <= cfgBaseCount;
          curAddr[c]  <= cfgBaseAddr;
          curCnt[c]   <= cfgBaseCount;
          pageReg[c]  <= cfgPage;
          modeReg[c]  <= cfgMode;
        end else if (strobe.fire && strobe.ch == CH_W'(c)) begin
          if (curCnt[c] == '0 && modeReg[c].autoInit) begin
            curAddr[c] <= baseAddr[c];
            curCnt[c]  <= baseCnt[c];
          end else begin
            curCnt[c]  <= curCnt[c] - ONE;
            curAddr[c] <= modeReg[c].addrDown ? curAddr[c] - ONE : curAddr[c] + ONE;
          end
        end
        if (maskWe && maskCh == CH_W'(c))
          maskReg[c] <= maskVal;
        else if (strobe.fire && strobe.ch == CH_W'(c) && curCnt[c] == '0 && !modeReg[c].autoInit)
          maskReg[c] <= 1'b1;
      end
    end
  end

  assign maskVec = maskReg;
  assign selType = modeReg[strobe.ch].xferType;
  assign selSvc  = modeReg[strobe.ch].svcMode;
  assign selTc   = (curCnt[strobe.ch] == '0);
  assign selPhys = {pageReg[strobe.ch], curAddr[strobe.ch]};
  assign rdAddr  = curAddr[rdCh];
  assign rdCount = curCnt[rdCh];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R6: terminal count in auto-initialize restores the base values
    assert_autoinit_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.fire && strobe.ch == CH_W'(g) && curCnt[g] == '0 && modeReg[g].autoInit
        && !(cfgLoad && cfgCh == CH_W'(g)))
      |=> (curCnt[g] == baseCnt[g] && curAddr[g] == baseAddr[g]));

    // R11: terminal count without auto-initialize self-masks and leaves all ones
    assert_tc_selfmask_R11: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.fire && strobe.ch == CH_W'(g) && curCnt[g] == '0 && !modeReg[g].autoInit
        && !(cfgLoad && cfgCh == CH_W'(g)) && !(maskWe && maskCh == CH_W'(g)))
      |=> (maskReg[g] && curCnt[g] == '1));

    // R7: an upward byte moves the address by exactly one
    assert_addr_up_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.fire && strobe.ch == CH_W'(g) && curCnt[g] != '0 && !modeReg[g].addrDown
        && !(cfgLoad && cfgCh == CH_W'(g)))
      |=> (curAddr[g] == $past(curAddr[g]) + ONE && $stable(pageReg[g])));
  end
endmodule

// File: rtl/dma_eng_control.sv
module dma_eng_control
  import dma_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [NUM_CH-1:0] maskVec,
  input  xferType_e         selType,
  input  svcMode_e          selSvc,
  input  logic              selTc,
  output xferStrobe_t       strobe,
  output logic [NUM_CH-1:0] dack,
  output logic [NUM_CH-1:0] tcPulse,
  output logic              memWrite,
  output logic              memRead
);
  typedef enum logic {ST_IDLE, ST_XFER} state_e;

  state_e            state;
  logic [CH_W-1:0]   owner;
  logic [NUM_CH-1:0] pending;
  logic [CH_W-1:0]   pick;
  logic              found;
  logic              fire;
  logic              keepGoing;

  assign pending = dreq & ~maskVec;

  // fixed priority: lowest channel number wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pick  = CH_W'(i);
        found = 1'b1;
      end
    end
  end

  assign fire = (state == ST_XFER) && !maskVec[owner];

  always_comb begin
    unique case (selSvc)
      SVC_BLOCK:  keepGoing = 1'b1;
      SVC_DEMAND: keepGoing = dreq[owner];
      default:    keepGoing = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      owner <= '0;
    end else if (state == ST_IDLE) begin
      if (found) begin
        state <= ST_XFER;
        owner <= pick;
      end
    end else if (!fire || selTc || !keepGoing) begin
      state <= ST_IDLE;
    end
  end

  always_comb begin
    dack    = '0;
    tcPulse = '0;
    if (fire) begin
      dack[owner]    = 1'b1;
      tcPulse[owner] = selTc;
    end
  end

  assign strobe.fire = fire;
  assign strobe.ch   = owner;
  assign memWrite    = fire && selType == XFER_WRITE;
  assign memRead     = fire && selType == XFER_READ;

  assert_dack_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dack));

  assert_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pending[0]) |=> (strobe.ch == '0));

  assert_no_masked_dack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|dack) |-> ((dack & maskVec) == '0));

  assert_single_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((|dack) && selSvc == SVC_SINGLE) |=> (dack == '0));

  assert_tc_ends_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|tcPulse) |=> (dack == '0));
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [CH_W-1:0]          cfgCh,
  input  logic [ADDR_W-1:0]        cfgBaseAddr,
  input  logic [ADDR_W-1:0]        cfgBaseCount,
  input  logic [PAGE_W-1:0]        cfgPage,
  input  logic [1:0]               cfgXferType,
  input  logic                     cfgAutoInit,
  input  logic                     cfgAddrDown,
  input  logic [1:0]               cfgSvcMode,
  input  logic                     maskWe,
  input  logic [CH_W-1:0]          maskCh,
  input  logic                     maskVal,
  input  logic [NUM_CH-1:0]        dreq,
  output logic [NUM_CH-1:0]        dack,
  output logic [NUM_CH-1:0]        tcPulse,
  output logic [PAGE_W+ADDR_W-1:0] physAddr,
  output logic                     memWrite,
  output logic                     memRead,
  input  logic [CH_W-1:0]          rdCh,
  output logic [ADDR_W-1:0]        rdAddr,
  output logic [ADDR_W-1:0]        rdCount,
  output logic [NUM_CH-1:0]        maskOut
);
  chanMode_t   cfgMode;
  xferStrobe_t strobe;
  xferType_e   selType;
  svcMode_e    selSvc;
  logic        selTc;

  assign cfgMode.xferType = xferType_e'(cfgXferType);
  assign cfgMode.autoInit = cfgAutoInit;
  assign cfgMode.addrDown = cfgAddrDown;
  assign cfgMode.svcMode  = svcMode_e'(cfgSvcMode);

  dma_eng_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgLoad(cfgLoad), .cfgCh(cfgCh), .cfgBaseAddr(cfgBaseAddr),
    .cfgBaseCount(cfgBaseCount), .cfgPage(cfgPage), .cfgMode(cfgMode),
    .maskWe(maskWe), .maskCh(maskCh), .maskVal(maskVal), .rdCh(rdCh),
    .maskVec(maskOut), .selType(selType), .selSvc(selSvc), .selTc(selTc),
    .selPhys(physAddr), .rdAddr(rdAddr), .rdCount(rdCount)
  );

  dma_eng_control u_control (
    .clk(clk), .rstN(rstN), .dreq(dreq), .maskVec(maskOut),
    .selType(selType), .selSvc(selSvc), .selTc(selTc), .strobe(strobe),
    .dack(dack), .tcPulse(tcPulse), .memWrite(memWrite), .memRead(memRead)
  );
endmodule

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [1:0] cfgCh = '0;
  logic [15:0] cfgBaseAddr = '0, cfgBaseCount = '0;
  logic [3:0] cfgPage = '0;
  logic [1:0] cfgXferType = '0, cfgSvcMode = '0;
  logic cfgAutoInit = 1'b0, cfgAddrDown = 1'b0;
  logic maskWe = 1'b0, maskVal = 1'b0;
  logic [1:0] maskCh = '0, rdCh = '0;
  logic [3:0] dreq = '0;
  logic [3:0] dack, tcPulse, maskOut;
  logic [19:0] physAddr;
  logic memWrite, memRead;
  logic [15:0] rdAddr, rdCount;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] mAddr [4], mCnt [4], mBaseA [4], mBaseC [4];
  logic [3:0] mPage [4];
  logic [1:0] mType [4], mSvc [4];
  bit mDown [4], mAuto [4];
  int nXfer [4], nTc [4], firstCyc [4], lastCyc [4];
  logic [3:0] prevD = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_xfer_engine u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCh(cfgCh),
    .cfgBaseAddr(cfgBaseAddr), .cfgBaseCount(cfgBaseCount), .cfgPage(cfgPage),
    .cfgXferType(cfgXferType), .cfgAutoInit(cfgAutoInit), .cfgAddrDown(cfgAddrDown),
    .cfgSvcMode(cfgSvcMode), .maskWe(maskWe), .maskCh(maskCh), .maskVal(maskVal),
    .dreq(dreq), .dack(dack), .tcPulse(tcPulse), .physAddr(physAddr),
    .memWrite(memWrite), .memRead(memRead), .rdCh(rdCh), .rdAddr(rdAddr),
    .rdCount(rdCount), .maskOut(maskOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-transfer checking against the arithmetic model
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 4; c++) begin
        if (dack[c]) begin
          chk(physAddr == {mPage[c], mAddr[c]}, "R3 R2 R7 address", 32'(physAddr), 32'({mPage[c], mAddr[c]}));
          chk(tcPulse[c] == (mCnt[c] == 16'h0), "R8 tc pulse", 32'(tcPulse), 32'(mCnt[c] == 16'h0));
          chk(memWrite == (mType[c] == 2'b01) && memRead == (mType[c] == 2'b10), "R5 strobes",
              32'({memWrite, memRead}), 32'({mType[c] == 2'b01, mType[c] == 2'b10}));
          if (mSvc[c] == 2'b01 && prevD[c]) chk(1'b0, "R9 single gap", 32'(dack), 32'h0);
          if (nXfer[c] == 0) firstCyc[c] = cyc;
          lastCyc[c] = cyc;
          nXfer[c]++;
          if (tcPulse[c]) nTc[c]++;
          if (mCnt[c] == 16'h0 && mAuto[c]) begin
            mAddr[c] = mBaseA[c];
            mCnt[c]  = mBaseC[c];
          end else begin
            mCnt[c]  = mCnt[c] - 16'h1;
            mAddr[c] = mDown[c] ? mAddr[c] - 16'h1 : mAddr[c] + 16'h1;
          end
        end else if (tcPulse[c]) begin
          chk(1'b0, "R8 pulse without transfer", 32'(tcPulse), 32'h0);
        end
      end
      if (dack != 4'h0 && !$onehot(dack)) chk(1'b0, "R10 onehot", 32'(dack), 32'h0);
      prevD = dack;
    end
  end

  task automatic clearStats();
    for (int c = 0; c < 4; c++) begin
      nXfer[c] = 0; nTc[c] = 0; firstCyc[c] = 0; lastCyc[c] = 0;
    end
  endtask

  task automatic cfgChan(input int ch, input logic [15:0] a, input logic [15:0] n, input logic [3:0] pg,
                         input logic [1:0] ty, input bit au, input bit dn, input logic [1:0] sv);
    @(negedge clk);
    cfgLoad = 1'b1; cfgCh = 2'(ch); cfgBaseAddr = a; cfgBaseCount = n; cfgPage = pg;
    cfgXferType = ty; cfgAutoInit = au; cfgAddrDown = dn; cfgSvcMode = sv;
    mAddr[ch] = a; mCnt[ch] = n; mBaseA[ch] = a; mBaseC[ch] = n; mPage[ch] = pg;
    mType[ch] = ty; mAuto[ch] = au; mDown[ch] = dn; mSvc[ch] = sv;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic setMask(input int ch, input bit v);
    maskWe = 1'b1; maskCh = 2'(ch); maskVal = v;
    @(negedge clk);
    maskWe = 1'b0;
  endtask

  task automatic readCh(input int ch);
    rdCh = 2'(ch);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearStats();
    for (int c = 0; c < 4; c++) begin
      mAddr[c] = '0; mCnt[c] = '0; mBaseA[c] = '0; mBaseC[c] = '0; mPage[c] = '0;
      mType[c] = '0; mSvc[c] = '0; mAuto[c] = 0; mDown[c] = 0;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    readCh(1);
    chk(dack == 4'h0 && tcPulse == 4'h0 && !memWrite && !memRead, "R12 idle outputs", 32'({dack, tcPulse}), 32'h0);
    chk(maskOut == 4'hF, "R12 all masked", 32'(maskOut), 32'hF);
    chk(rdCount == 16'h0, "R12 count", 32'(rdCount), 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // single mode, write, incrementing across FFFFh, count 3 on channel 1
    cfgChan(1, 16'hFFFE, 16'd3, 4'h5, 2'b01, 0, 0, 2'b01);
    setMask(1, 0);
    dreq[1] = 1'b1;
    repeat (20) @(negedge clk);
    dreq[1] = 1'b0;
    repeat (2) @(negedge clk);
    readCh(1);
    chk(nXfer[1] == 4, "R1 bytes for count 3", 32'(nXfer[1]), 32'd4);
    chk(nTc[1] == 1, "R8 one tc", 32'(nTc[1]), 32'd1);
    chk(lastCyc[1] - firstCyc[1] == 6, "R9 single spacing", 32'(lastCyc[1] - firstCyc[1]), 32'd6);
    chk(maskOut[1] == 1'b1, "R11 self mask", 32'(maskOut), 32'h2);
    chk(rdCount == 16'hFFFF, "R11 count all ones", 32'(rdCount), 32'hFFFF);
    chk(rdAddr == 16'h0002, "R2 wrapped address", 32'(rdAddr), 32'h2);

    // block mode, read, decrementing, count 5 on channel 2
    clearStats();
    cfgChan(2, 16'h0010, 16'd5, 4'h3, 2'b10, 0, 1, 2'b10);
    setMask(2, 0);
    dreq[2] = 1'b1;
    @(negedge clk);
    dreq[2] = 1'b0;
    repeat (15) @(negedge clk);
    readCh(2);
    chk(nXfer[2] == 6, "R1 block bytes", 32'(nXfer[2]), 32'd6);
    chk(lastCyc[2] - firstCyc[2] == 5, "R9 block back to back", 32'(lastCyc[2] - firstCyc[2]), 32'd5);
    chk(rdAddr == 16'h000A, "R7 decrement end address", 32'(rdAddr), 32'hA);

    // block mode, count 0 moves one byte
    clearStats();
    cfgChan(2, 16'h8000, 16'd0, 4'h1, 2'b10, 0, 0, 2'b10);
    setMask(2, 0);
    dreq[2] = 1'b1;
    @(negedge clk);
    dreq[2] = 1'b0;
    repeat (6) @(negedge clk);
    chk(nXfer[2] == 1 && nTc[2] == 1, "R1 count zero", 32'(nXfer[2]), 32'd1);

    // demand mode, verify, channel 0, request held four cycles
    clearStats();
    cfgChan(0, 16'h1000, 16'd9, 4'h0, 2'b00, 0, 0, 2'b00);
    setMask(0, 0);
    dreq[0] = 1'b1;
    repeat (4) @(negedge clk);
    dreq[0] = 1'b0;
    repeat (6) @(negedge clk);
    readCh(0);
    chk(nXfer[0] == 4, "R9 demand stops with request", 32'(nXfer[0]), 32'd4);
    chk(rdCount == 16'd9 - 16'(nXfer[0]), "R9 demand remaining", 32'(rdCount), 32'(16'd9 - 16'(nXfer[0])));
    chk(maskOut[0] == 1'b0, "R9 demand channel still open", 32'(maskOut), 32'h0);

    // auto-initialize, block, channel 3, two rounds
    clearStats();
    cfgChan(3, 16'h0200, 16'd2, 4'h7, 2'b01, 1, 0, 2'b10);
    setMask(3, 0);
    for (int r = 0; r < 2; r++) begin
      dreq[3] = 1'b1;
      @(negedge clk);
      dreq[3] = 1'b0;
      repeat (8) @(negedge clk);
      readCh(3);
      chk(rdCount == 16'd2 && rdAddr == 16'h0200, "R6 reload", 32'({rdCount, rdAddr}), 32'h0002_0200);
      chk(maskOut[3] == 1'b0, "R6 stays unmasked", 32'(maskOut), 32'h0);
    end
    chk(nXfer[3] == 6 && nTc[3] == 2, "R6 two full rounds", 32'(nXfer[3]), 32'd6);

    // fixed priority: channel 0 and channel 3 request together
    clearStats();
    cfgChan(0, 16'h3000, 16'd2, 4'h2, 2'b01, 0, 0, 2'b01);
    cfgChan(3, 16'h4000, 16'd2, 4'h4, 2'b10, 0, 0, 2'b01);
    setMask(0, 0);
    dreq[0] = 1'b1; dreq[3] = 1'b1;
    repeat (20) @(negedge clk);
    dreq = '0;
    @(negedge clk);
    chk(nXfer[0] == 3 && nXfer[3] == 3, "R10 both served", 32'({nXfer[0][15:0], nXfer[3][15:0]}), 32'h0003_0003);
    chk(lastCyc[0] < firstCyc[3], "R10 channel 0 first", 32'(lastCyc[0]), 32'(firstCyc[3]));

    // pause and resume, block, channel 1
    clearStats();
    cfgChan(1, 16'h0040, 16'd7, 4'h2, 2'b10, 0, 0, 2'b10);
    setMask(1, 0);
    dreq[1] = 1'b1;
    @(negedge clk);
    dreq[1] = 1'b0;
    @(negedge clk);
    setMask(1, 1);
    repeat (10) @(negedge clk);
    readCh(1);
    chk(nXfer[1] > 0 && nXfer[1] < 8, "R4 paused mid transfer", 32'(nXfer[1]), 32'd2);
    chk(rdCount == 16'd7 - 16'(nXfer[1]), "R4 count kept", 32'(rdCount), 32'(16'd7 - 16'(nXfer[1])));
    chk(rdAddr == 16'h0040 + 16'(nXfer[1]), "R4 address kept", 32'(rdAddr), 32'(16'h0040 + 16'(nXfer[1])));
    dreq[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk(dack[1] == 1'b0, "R4 masked ignores request", 32'(dack), 32'h0);
    dreq[1] = 1'b0;
    setMask(1, 0);
    dreq[1] = 1'b1;
    @(negedge clk);
    dreq[1] = 1'b0;
    repeat (12) @(negedge clk);
    chk(nXfer[1] == 8 && nTc[1] == 1, "R4 resumed to end", 32'(nXfer[1]), 32'd8);

    // full 64 KB block on channel 2
    clearStats();
    cfgChan(2, 16'h0000, 16'hFFFF, 4'hA, 2'b01, 0, 0, 2'b10);
    setMask(2, 0);
    dreq[2] = 1'b1;
    @(negedge clk);
    dreq[2] = 1'b0;
    repeat (65545) @(negedge clk);
    readCh(2);
    chk(nXfer[2] == 65536, "R1 full page", 32'(nXfer[2]), 32'd65536);
    chk(nTc[2] == 1, "R8 single tc in full page", 32'(nTc[2]), 32'd1);
    chk(rdAddr == 16'h0000 && rdCount == 16'hFFFF, "R2 wrap stays in page", 32'({rdAddr, rdCount}), 32'h0000_FFFF);
    chk(maskOut[2] == 1'b1, "R11 full page self mask", 32'(maskOut), 32'h4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule